// File: doc/BRIEF.md
# Type-II Digital Tracking Position Loop

This block makes a registered position word follow a sampled, signed position input. Each clock it compares the input with its own position counter. The difference feeds two integrations in series. The first is an error integrator whose value is the loop's velocity estimate. The second is the position counter itself, which is advanced by a phase accumulator that acts as a rate-controlled step generator. With two integrators in the loop, the counter runs at the input's rate with no steady lag once a constant-rate input has settled.

The counter only ever moves by one step at a time, and each move is flagged by a one-cycle `step_t` pulse. A resolution input selects fine steps of one LSB or coarse steps to the next multiple of four. A large error pulls the active-low fault flag low, and while the flag is low the loop runs with coarse steps so that it can slew back to null four times faster. The counter saturates at both ends of the two's-complement range.

The block is placed after whatever front end produces the digital position word. The host reads `pos_out`, `vel_out` and `bit_n` directly.

Top module: `trk_loop`

## Requirements
- R1: While `rst_n` is low, `pos_out` is 0, `vel_out` is 0, `step_t` is 0 and `bit_n` is 1. The phase accumulator is also cleared.
- R2: `pos_out` changes on a clock edge only if `step_t` is 1 after that edge, and every change is a single step.
- R3: `pos_out` is two's complement (14 bits by default). It never steps above 0x1FFF (+FS-1 LSB) or below 0x2000 (-FS), and it never wraps. A held full-scale input pins it at that limit.
- R4: In fine mode (`res_hi`=1 and `bit_n`=1) a step changes `pos_out` by exactly +1 or -1. In coarse mode an up step moves to the next higher multiple of 4 and a down step moves to the next lower multiple of 4, so the two low bits are 0 after every coarse step.
- R5: `bit_n` becomes 0 on the edge after a cycle in which |`pos_in` - `pos_out`| exceeds 65. It becomes 1 on the edge after a cycle in which that magnitude is 65 or less.
- R6: A step taken while `bit_n` is 0 is a coarse step, whatever the value of `res_hi`.
- R7: On each edge `vel_out` gains the error `pos_in` - `pos_out` from the cycle before, saturating at ±16368 rather than wrapping.
- R8: Each cycle the signed rate (`vel_out` arithmetically shifted right by 4) + 16·error is formed and its magnitude is clipped to 1023. That magnitude is added into a 10-bit accumulator. A carry out requests one step in the direction of the rate's sign, and the step is taken unless the counter is at the limit in that direction. At most one step is taken per cycle.
- R9: After a step input, the loop locks: within 8000 cycles |error| is at most 4 in fine mode and at most 8 in coarse mode, and `bit_n` is 1.
- R10: With an input ramp of one LSB every 8 cycles in fine mode, the settled error stays within ±4 LSB and the velocity word carries the ramp rate (`vel_out`/16 near 128).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pos_in | input | 14 | Sampled signed position to be tracked |
| res_hi | input | 1 | 1 selects fine steps, 0 selects coarse steps |
| pos_out | output | 14 | Tracked position, two's complement |
| step_t | output | 1 | One-cycle pulse marking a counter step |
| vel_out | output | 16 | Signed error-integrator value (velocity word) |
| bit_n | output | 1 | Active-low large-error fault flag |

## Verification
The hardest condition to reach from the ports is a counter pressed against a limit stop. The input itself cannot exceed full scale, so the saturation only matters when the loop tries to move past the input. The stimulus drives the input to +FS-1 and then to -FS after the integrator has wound up on long slews, so the loop keeps requesting steps beyond the end of the range. The fault-forced coarse mode is reached with a step in fine mode that is much larger than 65 LSB. A behavioural model of the loop is compared against the outputs on every cycle throughout.

// File: rtl/trk_pkg.sv
`timescale 1ns/1ps
package trk_pkg;
   typedef enum logic {DIR_UP = 1'b0, DIR_DN = 1'b1} step_dir_e;

   typedef struct packed {
      logic      req;
      step_dir_e dir;
   } step_req_t;
endpackage

// File: rtl/trk_err_integ.sv
`timescale 1ns/1ps
module trk_err_integ #(
   parameter int POS_W   = 14,
   parameter int INT_W   = 16,
   parameter int VEL_MAX = 16368,
   parameter int BIT_THR = 65,
   localparam int ERR_W  = POS_W + 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [POS_W-1:0]        pos_in,
   input  logic [POS_W-1:0]        cnt,
   output logic signed [ERR_W-1:0] err,
   output logic signed [INT_W-1:0] vel,
   output logic                    bit_n
);
   localparam logic signed [INT_W:0] VHI = (INT_W+1)'(VEL_MAX);
   localparam logic signed [INT_W:0] VLO = -(INT_W+1)'(VEL_MAX);
   localparam logic [ERR_W-1:0]      THR = ERR_W'(BIT_THR);

   logic [ERR_W-1:0]        err_mag;
   logic signed [INT_W:0]   vel_sum;
   logic signed [INT_W-1:0] vel_nxt;

   assign err     = ERR_W'($signed(pos_in)) - ERR_W'($signed(cnt));
   assign err_mag = err[ERR_W-1] ? ERR_W'(-err) : ERR_W'(err);
   assign vel_sum = (INT_W+1)'(vel) + (INT_W+1)'(err);

   always_comb begin
      if (vel_sum > VHI)      vel_nxt = INT_W'(VHI);
      else if (vel_sum < VLO) vel_nxt = INT_W'(VLO);
      else                    vel_nxt = INT_W'(vel_sum);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vel   <= '0;
         bit_n <= 1'b1;
      end else begin
         vel   <= vel_nxt;
         bit_n <= !(err_mag > THR);
      end
   end
endmodule

// File: rtl/trk_step_gen.sv
`timescale 1ns/1ps
module trk_step_gen
   import trk_pkg::*;
#(
   parameter int ERR_W = 15,
   parameter int INT_W = 16,
   parameter int ACC_W = 10,
   parameter int KP_SH = 4,
   parameter int KV_SH = 4,
   localparam int RATE_W = ((INT_W > ERR_W + KP_SH) ? INT_W : ERR_W + KP_SH) + 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic signed [ERR_W-1:0] err,
   input  logic signed [INT_W-1:0] vel,
   output step_req_t               req
);
   localparam logic [RATE_W-1:0] LIM = RATE_W'((64'd1 << ACC_W) - 64'd1);

   logic signed [RATE_W-1:0] v_ext, v_term, e_term, rate;
   logic [RATE_W-1:0]        mag, mag_clip;
   logic [ACC_W-1:0]         acc;
   logic [ACC_W:0]           acc_sum;

   assign v_ext  = RATE_W'(vel);
   assign v_term = v_ext >>> KV_SH;
   assign e_term = RATE_W'(err) <<< KP_SH;
   assign rate   = v_term + e_term;
   assign mag    = rate[RATE_W-1] ? RATE_W'(-rate) : RATE_W'(rate);

   always_comb begin
      mag_clip = (mag > LIM) ? LIM : mag;
   end

   assign acc_sum = {1'b0, acc} + {1'b0, mag_clip[ACC_W-1:0]};
   assign req.req = acc_sum[ACC_W];
   assign req.dir = rate[RATE_W-1] ? DIR_DN : DIR_UP;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc <= '0;
      else        acc <= acc_sum[ACC_W-1:0];
   end
endmodule

// File: rtl/trk_sat_counter.sv
`timescale 1ns/1ps
module trk_sat_counter
   import trk_pkg::*;
#(
   parameter int POS_W  = 14,
   parameter int CRS_SH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  step_req_t        req,
   input  logic             coarse,
   output logic [POS_W-1:0] cnt,
   output logic             step
);
   localparam logic [POS_W-1:0] TOP  = {1'b0, {(POS_W-1){1'b1}}};
   localparam logic [POS_W-1:0] BOT  = {1'b1, {(POS_W-1){1'b0}}};
   localparam logic [POS_W-1:0] LOWM = POS_W'((64'd1 << CRS_SH) - 64'd1);

   logic [POS_W-1:0] mask, up_nxt, dn_nxt;
   logic             up_ok, dn_ok, fire;

   assign mask   = coarse ? LOWM : '0;
   assign up_nxt = (cnt | mask) + POS_W'(1);
   assign dn_nxt = (cnt - POS_W'(1)) & ~mask;
   assign up_ok  = (cnt | mask) != TOP;
   assign dn_ok  = cnt != BOT;
   assign fire   = req.req && ((req.dir == DIR_DN) ? dn_ok : up_ok);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         step <= 1'b0;
      end else begin
         step <= fire;
         if (fire) cnt <= (req.dir == DIR_DN) ? dn_nxt : up_nxt;
      end
   end
endmodule

// File: rtl/trk_loop.sv
`timescale 1ns/1ps
module trk_loop
   import trk_pkg::*;
#(
   parameter int POS_W   = 14,
   parameter int CRS_SH  = 2,
   parameter int INT_W   = 16,
   parameter int ACC_W   = 10,
   parameter int KP_SH   = 4,
   parameter int KV_SH   = 4,
   parameter int VEL_MAX = 16368,
   parameter int BIT_THR = 65
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [POS_W-1:0] pos_in,
   input  logic             res_hi,
   output logic [POS_W-1:0] pos_out,
   output logic             step_t,
   output logic [INT_W-1:0] vel_out,
   output logic             bit_n
);
   localparam int ERR_W = POS_W + 1;

   if (POS_W < CRS_SH + 2) begin : g_bad_pos
      $error("trk_loop: POS_W too small for CRS_SH");
   end
   if (INT_W < ERR_W) begin : g_bad_int
      $error("trk_loop: INT_W must hold the error word");
   end
   if (VEL_MAX >= (1 << (INT_W - 1))) begin : g_bad_vel
      $error("trk_loop: VEL_MAX exceeds INT_W range");
   end
   if (ACC_W < 2 || ACC_W > 30) begin : g_bad_acc
      $error("trk_loop: ACC_W out of range");
   end

   logic signed [ERR_W-1:0] err;
   logic signed [INT_W-1:0] vel;
   logic                    bit_q;
   logic                    coarse;
   step_req_t               req;

   trk_err_integ #(
      .POS_W(POS_W), .INT_W(INT_W), .VEL_MAX(VEL_MAX), .BIT_THR(BIT_THR)
   ) u_integ (
      .clk(clk), .rst_n(rst_n), .pos_in(pos_in), .cnt(pos_out),
      .err(err), .vel(vel), .bit_n(bit_q)
   );

   trk_step_gen #(
      .ERR_W(ERR_W), .INT_W(INT_W), .ACC_W(ACC_W), .KP_SH(KP_SH), .KV_SH(KV_SH)
   ) u_gen (
      .clk(clk), .rst_n(rst_n), .err(err), .vel(vel), .req(req)
   );

   if (CRS_SH > 0) begin : g_crs
      assign coarse = !res_hi || !bit_q;
   end else begin : g_fine_only
      assign coarse = 1'b0;
   end

   trk_sat_counter #(
      .POS_W(POS_W), .CRS_SH(CRS_SH)
   ) u_cnt (
      .clk(clk), .rst_n(rst_n), .req(req), .coarse(coarse),
      .cnt(pos_out), .step(step_t)
   );

   assign vel_out = vel;
   assign bit_n   = bit_q;
endmodule

// File: rtl/trk_loop_chk.sv
`timescale 1ns/1ps
module trk_loop_chk #(
   parameter int POS_W   = 14,
   parameter int CRS_SH  = 2,
   parameter int INT_W   = 16,
   parameter int VEL_MAX = 16368,
   parameter int BIT_THR = 65
) (
   input logic             clk,
   input logic             rst_n,
   input logic [POS_W-1:0] pos_in,
   input logic             res_hi,
   input logic [POS_W-1:0] pos_out,
   input logic             step_t,
   input logic [INT_W-1:0] vel_out,
   input logic             bit_n
);
   localparam logic [POS_W-1:0] LOWM = POS_W'((64'd1 << CRS_SH) - 64'd1);
   localparam int CSTEP = 1 << CRS_SH;

   logic [POS_W-1:0]        prev_pos;
   logic signed [POS_W:0]   d_err, delta;
   logic [POS_W:0]          d_mag;
   logic                    big;
   logic                    fine_mode;
   logic signed [INT_W-1:0] vs;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_pos <= '0;
      else        prev_pos <= pos_out;
   end

   assign d_err     = (POS_W+1)'($signed(pos_in)) - (POS_W+1)'($signed(pos_out));
   assign d_mag     = d_err[POS_W] ? (POS_W+1)'(-d_err) : (POS_W+1)'(d_err);
   assign big       = d_mag > (POS_W+1)'(BIT_THR);
   assign delta     = (POS_W+1)'($signed(pos_out)) - (POS_W+1)'($signed(prev_pos));
   assign fine_mode = res_hi && bit_n;
   assign vs        = $signed(vel_out);

   // R2
   hold_without_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !step_t |-> (pos_out == prev_pos));

   // R4
   fine_unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_t && $past(fine_mode)) |-> (delta == 1 || delta == -1));

   // R6
   coarse_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_t && !$past(fine_mode)) |-> ((pos_out & LOWM) == '0));

   // R3
   no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step_t |-> (delta != 0 && delta <= CSTEP && delta >= -CSTEP));

   // R5
   fault_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      big |=> !bit_n);

   // R5
   fault_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !big |=> bit_n);

   // R7
   vel_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vs <= VEL_MAX) && (vs >= -VEL_MAX));
endmodule

bind trk_loop trk_loop_chk #(
   .POS_W(POS_W), .CRS_SH(CRS_SH), .INT_W(INT_W), .VEL_MAX(VEL_MAX), .BIT_THR(BIT_THR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .pos_in(pos_in), .res_hi(res_hi), .pos_out(pos_out),
   .step_t(step_t), .vel_out(vel_out), .bit_n(bit_n)
);

// File: tb/sim_trk_loop.sv
`timescale 1ns/1ps
module sim_trk_loop;
   localparam int VMAX = 16368;
   localparam int WD_CYC = 190000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [13:0] pos_in = '0;
   logic        res_hi = 1'b1;
   logic [13:0] pos_out;
   logic        step_t;
   logic [15:0] vel_out;
   logic        bit_n;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;
   bit cmp_on = 1'b0;

   // behavioural reference state
   int m_cnt = 0, m_vel = 0, m_acc = 0, m_t = 0, m_bitn = 1;

   trk_loop u0 (
      .clk(clk), .rst_n(rst_n), .pos_in(pos_in), .res_hi(res_hi),
      .pos_out(pos_out), .step_t(step_t), .vel_out(vel_out), .bit_n(bit_n)
   );

   always #5 clk = ~clk;

   function automatic int iabs(int v);
      return (v < 0) ? -v : v;
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
      end
   endtask

   // reference loop, one update per rising edge
   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_vel = 0; m_acc = 0; m_t = 0; m_bitn = 1;
      end else begin
         int e, rate, mg, s, nv;
         bit crs, can, dn;
         e    = int'($signed(pos_in)) - m_cnt;
         crs  = (res_hi == 1'b0) || (m_bitn == 0);
         rate = (m_vel >>> 4) + e * 16;
         dn   = rate < 0;
         mg   = iabs(rate);
         if (mg > 1023) mg = 1023;
         s     = m_acc + mg;
         m_acc = s % 1024;
         if (dn) can = m_cnt > -8192;
         else    can = crs ? (m_cnt < 8188) : (m_cnt < 8191);
         m_t = (s >= 1024) && can;
         if (m_t) begin
            if (crs) m_cnt = dn ? ((m_cnt - 1) & ~3) : ((m_cnt | 3) + 1);
            else     m_cnt = dn ? m_cnt - 1 : m_cnt + 1;
         end
         nv = m_vel + e;
         if (nv > VMAX) nv = VMAX;
         if (nv < -VMAX) nv = -VMAX;
         m_vel  = nv;
         m_bitn = (iabs(e) > 65) ? 0 : 1;
      end
   end

   // cycle compare against the reference, away from the rising edge
   always @(negedge clk) begin
      if (cmp_on && rst_n) begin
         chk(int'($signed(pos_out)) == m_cnt, "R8 pos_out", int'($signed(pos_out)), m_cnt);
         chk(int'(step_t) == m_t, "R2 step_t", int'(step_t), m_t);
         chk(int'($signed(vel_out)) == m_vel, "R7 vel_out", int'($signed(vel_out)), m_vel);
         chk(int'(bit_n) == m_bitn, "R5 bit_n", int'(bit_n), m_bitn);
      end
   end

   task automatic cyc(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   int e_now;
   int coarse_hits, coarse_bad, bit_low_seen, max_err;
   bit prev_b;

   initial begin
      cyc(3);
      // R1 reset values
      chk(pos_out == 14'd0, "R1 pos_out", int'(pos_out), 0);
      chk(vel_out == 16'd0, "R1 vel_out", int'(vel_out), 0);
      chk(step_t == 1'b0, "R1 step_t", int'(step_t), 0);
      chk(bit_n == 1'b1, "R1 bit_n", int'(bit_n), 1);
      rst_n = 1'b1;
      cmp_on = 1'b1;

      // fine-mode step of 1000: fault must force coarse steps (R5, R6)
      pos_in = 14'(1000);
      res_hi = 1'b1;
      coarse_hits = 0; coarse_bad = 0; bit_low_seen = 0;
      prev_b = 1'b1;
      for (int i = 0; i < 8000; i++) begin
         @(negedge clk);
         if (!bit_n) bit_low_seen++;
         if (step_t && !prev_b) begin
            coarse_hits++;
            if (pos_out[1:0] != 2'b00) coarse_bad++;
         end
         prev_b = bit_n;
      end
      chk(bit_low_seen > 0, "R5 fault seen on large step", bit_low_seen, 1);
      chk(coarse_hits > 0, "R6 coarse steps under fault", coarse_hits, 1);
      chk(coarse_bad == 0, "R6 coarse steps aligned", coarse_bad, 0);
      e_now = 1000 - int'($signed(pos_out));
      chk(iabs(e_now) <= 4, "R9 fine lock error", e_now, 0);
      chk(bit_n == 1'b1, "R9 fault released", int'(bit_n), 1);

      // coarse-mode step to -2000 (R4)
      res_hi = 1'b0;
      pos_in = 14'(-2000);
      coarse_bad = 0;
      for (int i = 0; i < 8000; i++) begin
         @(negedge clk);
         if (step_t && pos_out[1:0] != 2'b00) coarse_bad++;
      end
      chk(coarse_bad == 0, "R4 coarse alignment", coarse_bad, 0);
      e_now = -2000 - int'($signed(pos_out));
      chk(iabs(e_now) <= 8, "R9 coarse lock error", e_now, 0);
      chk(bit_n == 1'b1, "R9 coarse fault released", int'(bit_n), 1);

      // fine-mode ramp, one LSB every 8 cycles (R10)
      res_hi = 1'b1;
      max_err = 0;
      for (int i = 0; i < 12000; i++) begin
         @(negedge clk);
         if (i >= 10000) begin
            e_now = int'($signed(pos_in)) - int'($signed(pos_out));
            if (iabs(e_now) > max_err) max_err = iabs(e_now);
         end
         if (i % 8 == 7) pos_in = pos_in + 14'd1;
      end
      chk(max_err <= 4, "R10 ramp lag", max_err, 0);
      chk((int'($signed(vel_out)) >>> 4) >= 112 && (int'($signed(vel_out)) >>> 4) <= 144,
          "R10 velocity word rate", int'($signed(vel_out)) >>> 4, 128);

      // upper limit stop (R3)
      pos_in = 14'h1FFF;
      cyc(8000);
      chk(pos_out == 14'h1FFF, "R3 upper stop", int'($signed(pos_out)), 8191);

      // lower limit stop in coarse mode (R3)
      res_hi = 1'b0;
      pos_in = 14'h2000;
      cyc(20000);
      chk(pos_out == 14'h2000, "R3 lower stop", int'($signed(pos_out)), -8192);
      cyc(50);
      chk(pos_out == 14'h2000, "R3 lower stop held", int'($signed(pos_out)), -8192);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (WD_CYC) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", WD_CYC, 0);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule